// File: doc/BRIEF.md
# ALU Self-Test Sequencer

This block checks a 16-bit, two-operand ALU without any host. It holds a fixed table of sixteen test vectors. For each vector it drives operand A, operand B and a 6-bit function code to the ALU. It waits for the result to settle, then compares the ALU's result with the expected value stored in the table. The vectors are ordered by operation group and use positive, negative, mixed-sign and boundary operands.

A rising edge on `start` launches a run. The first mismatch stops the run in a latched failure state. That state reports which case failed, together with the observed and expected results. If all sixteen cases match, the block enters a latched pass state and shows a display code that reads "GOOD". The ALU datapath is outside the block: the sequencer drives the ALU's inputs and reads its result through ports.

Top module: `alu_selftest_seq`

## Requirements
- R1: After reset, and whenever a reset arrives in the middle of a run, `busy`, `pass` and `fail` are low. `display_code` is 0x0000, and `alu_a`, `alu_b`, `alu_fn`, `fail_index`, `fail_observed` and `fail_expected` are all zero.
- R2: A run is launched only by a low-to-high change of `start` while the block is idle, passed or failed. Holding `start` high launches nothing further. A rising edge of `start` during a run has no effect on that run.
- R3: A run applies exactly 16 cases. The groups come in this order: additions (fn 000000), then subtractions (000001), then multiplications (000010), then all remaining operations. Case 0 is an addition. The other function codes are DIV=000011, AND=011000, OR=011110, XOR=010110, SHL=100000, SHR=100001, SRA=100011, CMPEQ=110011, CMPLT=110101, CMPLE=110111.
- R4: Each case lasts three cycles: apply, settle, compare. Operands and function code are held constant over all three cycles. Only the result present in the third cycle is compared. A clean run reaches `pass` 48 clock edges after the edge that launched it.
- R5: A mismatch in case k raises `fail` 3k+3 edges after the launch edge. No further case is applied: `busy` drops, and `alu_a`, `alu_b` and `alu_fn` return to zero.
- R6: While `fail` is high, `fail_index` holds k, `fail_observed` holds the ALU result that was compared, and `fail_expected` holds the table value. Outside the failure state all three read zero.
- R7: `pass` rises only after all 16 cases have matched, and `display_code` then reads 0x600D.
- R8: The pass and failure states, with all their outputs, are held until reset or a new rising edge of `start`. A new launch clears the previous failure report.
- R9: `busy` is high from the cycle after the launch edge until the pass or failure state is reached. At most one of `busy`, `pass` and `fail` is high at any time.
- R10: Across the table, the operands include 0x7FFF, 0x8000, 0xFFFF and 0x0000, as well as both positive and negative values.
- R11: During case k, `display_code` reads 0xB00k. In the failure state it reads 0xE00k, where k is the failing index in the low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request; the rising edge counts |
| alu_result | input | 16 | Result returned by the ALU under test |
| alu_a | output | 16 | Operand A to the ALU |
| alu_b | output | 16 | Operand B to the ALU |
| alu_fn | output | 6 | Function code to the ALU |
| busy | output | 1 | A run is in progress |
| pass | output | 1 | All cases matched (latched) |
| fail | output | 1 | A case mismatched (latched) |
| fail_index | output | 4 | Index of the failing case |
| fail_observed | output | 16 | ALU result captured at the mismatch |
| fail_expected | output | 16 | Expected value of the failing case |
| display_code | output | 16 | Status code: idle, running, GOOD or error |

## Verification
The bench injects faults into its own ALU model, one at a time: in the first case, in a middle case and in the very last case. A sequencer with an off-by-one stop condition or a miscounted case length would report the wrong index, fail after the wrong number of cycles, or declare a pass without reaching the last case. A separate run corrupts the ALU result in the first two cycles of every case. A design that samples too early would then fail a run that should pass. Other scenarios hold `start` high, pulse it in the middle of a run, and reset the block in the middle of a run. Each of these catches a level-triggered or retriggerable launch, or a report that does not clear.

// File: rtl/alu_st_pkg.sv
package alu_st_pkg;

    localparam int DATA_W    = 16;
    localparam int FN_W      = 6;
    localparam int NUM_CASES = 16;
    localparam int IDX_W     = $clog2(NUM_CASES);
    localparam int TAG_W     = 4;
    localparam int PAD_W     = DATA_W - TAG_W - IDX_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [FN_W-1:0]   fn_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Function codes seen by the ALU under test
    localparam fn_t FN_ADD   = 6'b000000;
    localparam fn_t FN_SUB   = 6'b000001;
    localparam fn_t FN_MUL   = 6'b000010;
    localparam fn_t FN_DIV   = 6'b000011;
    localparam fn_t FN_AND   = 6'b011000;
    localparam fn_t FN_OR    = 6'b011110;
    localparam fn_t FN_XOR   = 6'b010110;
    localparam fn_t FN_SHL   = 6'b100000;
    localparam fn_t FN_SHR   = 6'b100001;
    localparam fn_t FN_SRA   = 6'b100011;
    localparam fn_t FN_CMPEQ = 6'b110011;
    localparam fn_t FN_CMPLT = 6'b110101;
    localparam fn_t FN_CMPLE = 6'b110111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_SETTLE,
        ST_CHECK,
        ST_PASS,
        ST_FAIL
    } st_e;

    typedef struct packed {
        fn_t   fn;
        word_t a;
        word_t b;
        word_t exp;
    } vec_t;

    localparam word_t           DISP_IDLE = 16'h0000;
    localparam word_t           DISP_GOOD = 16'h600D;
    localparam logic [TAG_W-1:0] TAG_RUN  = 4'hB;
    localparam logic [TAG_W-1:0] TAG_ERR  = 4'hE;

endpackage

// File: rtl/alu_st_vectors.sv
module alu_st_vectors
    import alu_st_pkg::*;
(
    input  idx_t idx_i,
    output vec_t vec_o
);

    // Fixed case table: additions, subtractions, multiplications, then the rest
    always_comb begin
        case (idx_i)
            4'd0:    vec_o = '{fn: FN_ADD,   a: 16'h7FFF, b: 16'h0001, exp: 16'h8000};
            4'd1:    vec_o = '{fn: FN_ADD,   a: 16'hFFFF, b: 16'h0001, exp: 16'h0000};
            4'd2:    vec_o = '{fn: FN_SUB,   a: 16'h0000, b: 16'h0001, exp: 16'hFFFF};
            4'd3:    vec_o = '{fn: FN_SUB,   a: 16'h8000, b: 16'h0001, exp: 16'h7FFF};
            4'd4:    vec_o = '{fn: FN_MUL,   a: 16'h0003, b: 16'hFFFE, exp: 16'hFFFA};
            4'd5:    vec_o = '{fn: FN_MUL,   a: 16'h0100, b: 16'h0100, exp: 16'h0000};
            4'd6:    vec_o = '{fn: FN_AND,   a: 16'hF0F0, b: 16'hFF00, exp: 16'hF000};
            4'd7:    vec_o = '{fn: FN_OR,    a: 16'h00FF, b: 16'h0F00, exp: 16'h0FFF};
            4'd8:    vec_o = '{fn: FN_XOR,   a: 16'hFFFF, b: 16'h5A5A, exp: 16'hA5A5};
            4'd9:    vec_o = '{fn: FN_SHL,   a: 16'h0001, b: 16'h0004, exp: 16'h0010};
            4'd10:   vec_o = '{fn: FN_SHR,   a: 16'h8000, b: 16'h000F, exp: 16'h0001};
            4'd11:   vec_o = '{fn: FN_SRA,   a: 16'h8000, b: 16'h0004, exp: 16'hF800};
            4'd12:   vec_o = '{fn: FN_CMPEQ, a: 16'h8000, b: 16'h8000, exp: 16'h0001};
            4'd13:   vec_o = '{fn: FN_CMPLT, a: 16'hFFFF, b: 16'h0001, exp: 16'h0001};
            4'd14:   vec_o = '{fn: FN_CMPLE, a: 16'h0005, b: 16'hFFFB, exp: 16'h0000};
            4'd15:   vec_o = '{fn: FN_DIV,   a: 16'h0064, b: 16'h0007, exp: 16'h000E};
            default: vec_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_st_edge.sv
module alu_st_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic level_d, level_q;

    always_comb level_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/alu_st_ctrl.sv
module alu_st_ctrl
    import alu_st_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  launch_i,
    input  word_t result_i,
    input  vec_t  vec_i,
    output idx_t  idx_o,
    output logic  busy_o,
    output logic  pass_o,
    output logic  fail_o,
    output fn_t   alu_fn_o,
    output word_t alu_a_o,
    output word_t alu_b_o,
    output idx_t  fail_idx_o,
    output word_t fail_obs_o,
    output word_t fail_exp_o,
    output word_t display_o
);

    localparam idx_t LAST_IDX = idx_t'(NUM_CASES - 1);

    typedef struct packed {
        st_e   st;
        idx_t  idx;
        word_t obs;
        word_t exp;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  running;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (launch_i) begin
                    r_d.st  = ST_APPLY;
                    r_d.idx = '0;
                    r_d.obs = '0;
                    r_d.exp = '0;
                end
            end
            ST_APPLY:  r_d.st = ST_SETTLE;
            ST_SETTLE: r_d.st = ST_CHECK;
            ST_CHECK: begin
                if (result_i != vec_i.exp) begin
                    r_d.st  = ST_FAIL;
                    r_d.obs = result_i;
                    r_d.exp = vec_i.exp;
                end else if (r_q.idx == LAST_IDX) begin
                    r_d.st = ST_PASS;
                end else begin
                    r_d.st  = ST_APPLY;
                    r_d.idx = r_q.idx + idx_t'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, idx: '0, obs: '0, exp: '0};
        else        r_q <= r_d;
    end

    assign running    = (r_q.st == ST_APPLY) || (r_q.st == ST_SETTLE) || (r_q.st == ST_CHECK);
    assign idx_o      = r_q.idx;
    assign busy_o     = running;
    assign pass_o     = (r_q.st == ST_PASS);
    assign fail_o     = (r_q.st == ST_FAIL);
    assign alu_fn_o   = running ? vec_i.fn : '0;
    assign alu_a_o    = running ? vec_i.a  : '0;
    assign alu_b_o    = running ? vec_i.b  : '0;
    assign fail_idx_o = fail_o ? r_q.idx : '0;
    assign fail_obs_o = fail_o ? r_q.obs : '0;
    assign fail_exp_o = fail_o ? r_q.exp : '0;

    always_comb begin
        if (running)     display_o = {TAG_RUN, {PAD_W{1'b0}}, r_q.idx};
        else if (pass_o) display_o = DISP_GOOD;
        else if (fail_o) display_o = {TAG_ERR, {PAD_W{1'b0}}, r_q.idx};
        else             display_o = DISP_IDLE;
    end

    // R9
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, pass_o, fail_o}));

    // R4
    operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SETTLE || r_q.st == ST_CHECK) |->
            ($stable(alu_a_o) && $stable(alu_b_o) && $stable(alu_fn_o)));

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !launch_i) |=> (fail_o && $stable(fail_idx_o) && $stable(fail_obs_o)));

    // R7
    pass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> ($past(r_q.idx) == LAST_IDX && $past(r_q.st) == ST_CHECK));

    // R6
    fail_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (fail_obs_o != fail_exp_o));

    // R5
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (alu_fn_o == '0 && alu_a_o == '0 && alu_b_o == '0 && !busy_o));

    // R2
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHECK && result_i == vec_i.exp && r_q.idx != LAST_IDX)
            |=> (r_q.st == ST_APPLY && r_q.idx == $past(r_q.idx) + idx_t'(1)));

endmodule

// File: rtl/alu_selftest_seq.sv
module alu_selftest_seq
    import alu_st_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] alu_result,
    output logic [15:0] alu_a,
    output logic [15:0] alu_b,
    output logic [5:0]  alu_fn,
    output logic        busy,
    output logic        pass,
    output logic        fail,
    output logic [3:0]  fail_index,
    output logic [15:0] fail_observed,
    output logic [15:0] fail_expected,
    output logic [15:0] display_code
);

    logic launch;
    idx_t cur_idx;
    vec_t cur_vec;

    alu_st_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (start),
        .rise_o  (launch)
    );

    alu_st_vectors u_vectors (
        .idx_i (cur_idx),
        .vec_o (cur_vec)
    );

    alu_st_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .result_i   (alu_result),
        .vec_i      (cur_vec),
        .idx_o      (cur_idx),
        .busy_o     (busy),
        .pass_o     (pass),
        .fail_o     (fail),
        .alu_fn_o   (alu_fn),
        .alu_a_o    (alu_a),
        .alu_b_o    (alu_b),
        .fail_idx_o (fail_index),
        .fail_obs_o (fail_observed),
        .fail_exp_o (fail_expected),
        .display_o  (display_code)
    );

endmodule

// File: tb/tb_alu_selftest_seq.sv
`timescale 1ns/1ps
module tb_alu_selftest_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] alu_result;
    logic [15:0] alu_a, alu_b, fail_observed, fail_expected, display_code;
    logic [5:0]  alu_fn;
    logic        busy, pass, fail;
    logic [3:0]  fail_index;

    int checks = 0;
    int failures = 0;

    bit         fault_on = 1'b0;
    logic [5:0] fault_fn = 6'd0;
    bit         junk_on = 1'b0;
    int         age = 0;
    logic [37:0] prev_sig = '0;

    logic [5:0]  seen_fn [16];
    logic [15:0] seen_a  [16];
    logic [15:0] seen_b  [16];

    always #2 clk = ~clk;

    alu_selftest_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .alu_result(alu_result),
        .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn), .busy(busy), .pass(pass),
        .fail(fail), .fail_index(fail_index), .fail_observed(fail_observed),
        .fail_expected(fail_expected), .display_code(display_code)
    );

    function automatic logic [15:0] model(input logic [5:0] fn, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] prod;
        prod = {16'd0, a} * {16'd0, b};
        case (fn)
            6'b000000: return a + b;
            6'b000001: return a - b;
            6'b000010: return prod[15:0];
            6'b000011: return (b == 16'd0) ? 16'hFFFF : a / b;
            6'b011000: return a & b;
            6'b011110: return a | b;
            6'b010110: return a ^ b;
            6'b100000: return a << b[3:0];
            6'b100001: return a >> b[3:0];
            6'b100011: return $unsigned($signed(a) >>> b[3:0]);
            6'b110011: return {15'd0, a == b};
            6'b110101: return {15'd0, $signed(a) < $signed(b)};
            6'b110111: return {15'd0, $signed(a) <= $signed(b)};
            default:   return 16'h0000;
        endcase
    endfunction

    function automatic int group_rank(input logic [5:0] fn);
        if (fn == 6'b000000) return 0;
        if (fn == 6'b000001) return 1;
        if (fn == 6'b000010) return 2;
        return 3;
    endfunction

    // age: cycles the current operand set has been presented (0 = apply cycle)
    always @(negedge clk) begin
        if ({alu_fn, alu_a, alu_b} != prev_sig) age <= 0;
        else                                    age <= age + 1;
        prev_sig <= {alu_fn, alu_a, alu_b};
    end

    assign alu_result = model(alu_fn, alu_a, alu_b)
                      ^ ((fault_on && alu_fn == fault_fn) ? 16'h0001 : 16'h0000)
                      ^ ((junk_on && age < 2) ? 16'hFFFF : 16'h0000);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        summary_and_end();
    end

    task automatic check_idle(input string tag);
        chk({tag, " busy"}, busy, 0);
        chk({tag, " pass"}, pass, 0);
        chk({tag, " fail"}, fail, 0);
        chk({tag, " display"}, display_code, 16'h0000);
        chk({tag, " operands"}, {alu_fn, alu_a, alu_b}, 0);
        chk({tag, " report"}, {fail_index, fail_observed, fail_expected}, 0);
    endtask

    // Launch a run; n = edges from launch edge until busy drops
    task automatic run_suite(input int pulse_at, input bit hold_start, output int n);
        @(negedge clk) start = 1'b0;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        n = 0;
        @(negedge clk);
        if (!hold_start) start = 1'b0;
        chk("R9 busy after launch", busy, 1);
        while (busy && n < 200) begin
            int k;
            int ph;
            k  = n / 3;
            ph = n % 3;
            if (k < 16) begin
                if (ph == 0) begin
                    seen_fn[k] = alu_fn;
                    seen_a[k]  = alu_a;
                    seen_b[k]  = alu_b;
                    chk("R11 running display", display_code, {4'hB, 8'h00, 4'(k)});
                end else begin
                    chk("R4 operands held", {alu_fn, alu_a, alu_b}, {seen_fn[k], seen_a[k], seen_b[k]});
                end
            end
            if (pulse_at >= 0 && n == pulse_at)     start = 1'b1;
            if (pulse_at >= 0 && n == pulse_at + 1) start = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        repeat (5) @(negedge clk);
        chk("R2 no launch without edge", busy, 0);
    endtask

    task automatic t_clean_pass();
        int n;
        int bad_order;
        bit h7, h8, hf, h0, neg, posv;
        run_suite(-1, 1'b0, n);
        chk("R4 cycles to pass", n, 48);
        chk("R7 pass", pass, 1);
        chk("R7 GOOD code", display_code, 16'h600D);
        chk("R9 busy low at pass", {busy, fail}, 0);
        chk("R6 report zero on pass", {fail_index, fail_observed, fail_expected}, 0);
        chk("R3 first case add", seen_fn[0], 6'b000000);
        bad_order = 0;
        for (int i = 1; i < 16; i++)
            if (group_rank(seen_fn[i]) < group_rank(seen_fn[i-1])) bad_order++;
        chk("R3 group order", bad_order, 0);
        chk("R3 has sub", group_rank(seen_fn[2]) <= 1, 1);
        h7 = 0; h8 = 0; hf = 0; h0 = 0; neg = 0; posv = 0;
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 2; j++) begin
                logic [15:0] v;
                v = (j == 0) ? seen_a[i] : seen_b[i];
                if (v == 16'h7FFF) h7 = 1;
                if (v == 16'h8000) h8 = 1;
                if (v == 16'hFFFF) hf = 1;
                if (v == 16'h0000) h0 = 1;
                if (v[15]) neg = 1; else if (v != 0) posv = 1;
            end
        end
        chk("R10 boundary operands", {h7, h8, hf, h0}, 4'hF);
        chk("R10 both signs", {neg, posv}, 2'b11);
        repeat (6) @(negedge clk);
        chk("R8 pass held", {pass, busy, display_code}, {1'b1, 1'b0, 16'h600D});
    endtask

    task automatic t_fault(input logic [5:0] fn, input int exp_idx, input string name);
        int n;
        logic [15:0] good;
        fault_on = 1'b1;
        fault_fn = fn;
        run_suite(-1, 1'b0, n);
        good = model(seen_fn[exp_idx], seen_a[exp_idx], seen_b[exp_idx]);
        chk({"R5 cycles to fail ", name}, n, 3 * exp_idx + 3);
        chk({"R5 fail flag ", name}, {fail, pass, busy}, 3'b100);
        chk({"R5 no further case ", name}, {alu_fn, alu_a, alu_b}, 0);
        chk({"R6 index ", name}, fail_index, exp_idx);
        chk({"R6 observed ", name}, fail_observed, good ^ 16'h0001);
        chk({"R6 expected ", name}, fail_expected, good);
        chk({"R11 error code ", name}, display_code, {4'hE, 8'h00, 4'(exp_idx)});
        fault_on = 1'b0;
        repeat (8) @(negedge clk);
        chk({"R8 fail held ", name}, {fail, fail_index, fail_observed}, {1'b1, 4'(exp_idx), good ^ 16'h0001});
    endtask

    task automatic t_restart_clears();
        int n;
        run_suite(-1, 1'b0, n);
        chk("R8 restart reaches pass", {pass, fail}, 2'b10);
        chk("R8 restart cycles", n, 48);
        chk("R8 report cleared", {fail_index, fail_observed, fail_expected}, 0);
    endtask

    task automatic t_start_held();
        int n;
        run_suite(-1, 1'b1, n);
        chk("R2 held start run", n, 48);
        repeat (10) @(negedge clk);
        chk("R2 held start no relaunch", {pass, busy}, 2'b10);
        start = 1'b0;
    endtask

    task automatic t_midrun_pulse();
        int n;
        run_suite(10, 1'b0, n);
        chk("R2 mid-run edge ignored", n, 48);
        chk("R2 pass after pulse", pass, 1);
    endtask

    task automatic t_late_sample();
        int n;
        junk_on = 1'b1;
        run_suite(-1, 1'b0, n);
        junk_on = 1'b0;
        chk("R4 third-cycle sampling", {pass, fail}, 2'b10);
        chk("R4 third-cycle cycles", n, 48);
    endtask

    task automatic t_reset_midrun();
        @(negedge clk) start = 1'b0;
        @(negedge clk) start = 1'b1;
        repeat (20) @(negedge clk);
        start = 1'b0;
        chk("R9 busy mid-run", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid-run");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 stays idle", busy, 0);
    endtask

    initial begin
        t_reset();
        t_clean_pass();
        t_fault(6'b000000, 0, "first case");
        t_restart_clears();
        t_fault(6'b000010, 4, "middle case");
        t_fault(6'b000011, 15, "last case");
        t_restart_clears();
        t_start_held();
        t_midrun_pulse();
        t_late_sample();
        t_reset_midrun();
        summary_and_end();
    end

endmodule